// File: doc/BRIEF.md
# Sequential Restoring Word Divider

This block divides a double-word or a single-word dividend by a one-word divisor. Each request yields a one-word quotient, a one-word remainder and four status outputs. Unsigned and two's complement operation are both supported. A long-mode bit chooses the dividend width. In short mode the upper dividend word is built internally as a zero or sign extension of the lower word, and the upper dividend port is not used.

A request is accepted when `start` is high and the block is idle. The block then holds `busy` for the whole operation. It needs one setup cycle to take operand magnitudes and check for overflow and a zero divisor. It then runs one shift/subtract/restore step per quotient bit, and finishes with one sign-correction cycle. The results appear together with a single-cycle `done` pulse and stay on the outputs until the next request completes.

Top module: `divr_core`

## Requirements
- R1: With W=16, `done` rises exactly 18 clock cycles (W+2) after the edge that accepts `start`. `done` is high for one cycle only. `busy` is high from the accepting edge until `done` rises, and is low in the `done` cycle.
- R2: A `start` pulse that arrives while `busy` is high has no effect. The operation in progress keeps its captured operands and its timing.
- R3: In unsigned mode without overflow, `quot` is the floor of dividend/divisor and `rem` is the dividend minus quot*divisor. For example, 39424/105 gives 375 and 49, and 0x9EF0/0x018D gives 0x0066 and 0x00C2.
- R4: In short mode (`is_long`=0), the dividend is `dvd_lo` zero-extended in unsigned mode and sign-extended in signed mode. `dvd_hi` is ignored.
- R5: In signed mode the quotient truncates toward zero and the remainder takes the sign of the dividend. For example, 0x9A00/105 gives -248 and -72, and 0x6600/0xFF97 gives -248 and +72.
- R6: In unsigned mode, `flag_ovf` is set when the upper dividend word is greater than or equal to a non-zero divisor. Examples are 0x00010000/1 in long mode, while 0xFFFEFFFF/0xFFFF does not overflow.
- R7: In signed mode, `flag_ovf` is set when the true quotient lies outside -2^(W-1) to 2^(W-1)-1. So -32768/-1 overflows, and -32768/1 gives 0x8000 with no overflow.
- R8: A zero divisor sets `div_zero`, clears `flag_ovf`, and drives `quot`, `rem`, `flag_neg` and `flag_zero` to 0.
- R9: On a valid result, `flag_neg` equals bit W-1 of `rem` and `flag_zero` is set when `rem` is 0. When the result is an overflow, `quot`, `rem`, `flag_neg` and `flag_zero` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; accepted only when idle |
| is_signed | input | 1 | 1 selects two's complement operands |
| is_long | input | 1 | 1 selects a double-word dividend |
| dvd_hi | input | W | Upper dividend word (long mode only) |
| dvd_lo | input | W | Lower dividend word |
| dvsr | input | W | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse marking fresh results |
| quot | output | W | Quotient |
| rem | output | W | Remainder |
| flag_neg | output | 1 | Remainder is negative |
| flag_zero | output | 1 | Remainder is zero |
| flag_ovf | output | 1 | Quotient does not fit |
| div_zero | output | 1 | Divisor was zero |

## Verification
The assertions assume only that reset is applied before the first request. Operands are sampled only on the accepting edge, so no stability is assumed for the data inputs, and `start` may be driven at any time, including while busy. The remainder-bound property relies on the captured divisor magnitude staying unchanged while a request is in flight. The bench drives every input on the falling edge, and it deliberately re-pulses `start` with different operands in the middle of some operations. This confirms that such stray requests stay within what the block tolerates.

// File: rtl/divr_pkg.sv
package divr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PREP = 2'd1,
      ST_ITER = 2'd2,
      ST_FIX  = 2'd3
   } divr_state_t;

   typedef struct packed {
      logic neg;
      logic zero;
      logic ovf;
      logic dz;
   } divr_flags_t;

endpackage

// File: rtl/divr_prep.sv
module divr_prep #(
   parameter int W = 16
) (
   input  logic           is_signed,
   input  logic           is_long,
   input  logic [W-1:0]   hi,
   input  logic [W-1:0]   lo,
   input  logic [W-1:0]   d,
   output logic [W-1:0]   mag_hi,
   output logic [W-1:0]   mag_lo,
   output logic [W-1:0]   mag_d,
   output logic           q_neg,
   output logic           r_neg,
   output logic           pre_ovf,
   output logic           dz
);
   localparam int DW = 2 * W;

   logic [DW-1:0] dvd;
   logic [DW-1:0] dvd_mag;
   logic          dvd_neg;
   logic          d_neg;

   always_comb begin
      if (is_long)
         dvd = {hi, lo};
      else if (is_signed)
         dvd = {{W{lo[W-1]}}, lo};
      else
         dvd = {{W{1'b0}}, lo};
      dvd_neg = is_signed & dvd[DW-1];
      d_neg   = is_signed & d[W-1];
      dvd_mag = dvd_neg ? ({DW{1'b0}} - dvd) : dvd;
      mag_d   = d_neg ? ({W{1'b0}} - d) : d;
      mag_hi  = dvd_mag[DW-1:W];
      mag_lo  = dvd_mag[W-1:0];
      q_neg   = dvd_neg ^ d_neg;
      r_neg   = dvd_neg;
      dz      = (d == {W{1'b0}});
      pre_ovf = !dz && (mag_hi >= mag_d);
   end
endmodule

// File: rtl/divr_step.sv
module divr_step #(
   parameter int W = 16
) (
   input  logic [W-1:0] hi,
   input  logic [W-1:0] lo,
   input  logic [W-1:0] d,
   output logic [W-1:0] nhi,
   output logic [W-1:0] nlo
);
   logic         carry;
   logic [W-1:0] sh;
   logic [W-1:0] diff;
   logic         bor;
   logic         qb;

   always_comb begin
      carry       = hi[W-1];
      sh          = {hi[W-2:0], lo[W-1]};
      {bor, diff} = {1'b0, sh} - {1'b0, d};
      qb          = carry | ~bor;
      nhi         = qb ? diff : sh;
      nlo         = {lo[W-2:0], qb};
   end
endmodule

// File: rtl/divr_post.sv
module divr_post
   import divr_pkg::*;
#(
   parameter int W = 16
) (
   input  logic          is_signed,
   input  logic          q_neg,
   input  logic          r_neg,
   input  logic [W-1:0]  qmag,
   input  logic [W-1:0]  rmag,
   input  logic          pre_ovf,
   input  logic          dz,
   output logic [W-1:0]  q,
   output logic [W-1:0]  r,
   output divr_flags_t   flags
);
   localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

   logic rng_ovf;
   logic err;

   always_comb begin
      if (is_signed)
         rng_ovf = q_neg ? (qmag > HALF) : qmag[W-1];
      else
         rng_ovf = 1'b0;
      flags.dz   = dz;
      flags.ovf  = !dz && (pre_ovf || rng_ovf);
      err        = dz || flags.ovf;
      q          = err ? '0 : (q_neg ? ({W{1'b0}} - qmag) : qmag);
      r          = err ? '0 : (r_neg ? ({W{1'b0}} - rmag) : rmag);
      flags.neg  = !err && r[W-1];
      flags.zero = !err && (r == {W{1'b0}});
   end
endmodule

// File: rtl/divr_core.sv
module divr_core
   import divr_pkg::*;
#(
   parameter int W = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          is_signed,
   input  logic          is_long,
   input  logic [W-1:0]  dvd_hi,
   input  logic [W-1:0]  dvd_lo,
   input  logic [W-1:0]  dvsr,
   output logic          busy,
   output logic          done,
   output logic [W-1:0]  quot,
   output logic [W-1:0]  rem,
   output logic          flag_neg,
   output logic          flag_zero,
   output logic          flag_ovf,
   output logic          div_zero
);
   localparam int LAT = W + 2;
   localparam int CW  = $clog2(W + 1);
   localparam int LW  = $clog2(LAT + 3);

   generate
      if (W < 4) begin : g_bad_width
         $error("divr_core: W must be at least 4");
      end
   endgenerate

   divr_state_t  st_q;
   logic [CW-1:0] cnt_q;
   logic          sgn_q, lng_q;
   logic [W-1:0]  hi_q, lo_q, d_q;
   logic          qn_q, rn_q, povf_q, dz_q;

   logic [W-1:0]  p_hi, p_lo, p_d;
   logic          p_qn, p_rn, p_ovf, p_dz;
   logic [W-1:0]  s_hi, s_lo;
   logic [W-1:0]  o_q, o_r;
   divr_flags_t   o_f;

   divr_prep #(.W(W)) prep_i (
      .is_signed(sgn_q), .is_long(lng_q), .hi(hi_q), .lo(lo_q), .d(d_q),
      .mag_hi(p_hi), .mag_lo(p_lo), .mag_d(p_d),
      .q_neg(p_qn), .r_neg(p_rn), .pre_ovf(p_ovf), .dz(p_dz)
   );

   divr_step #(.W(W)) step_i (
      .hi(hi_q), .lo(lo_q), .d(d_q), .nhi(s_hi), .nlo(s_lo)
   );

   divr_post #(.W(W)) post_i (
      .is_signed(sgn_q), .q_neg(qn_q), .r_neg(rn_q),
      .qmag(lo_q), .rmag(hi_q), .pre_ovf(povf_q), .dz(dz_q),
      .q(o_q), .r(o_r), .flags(o_f)
   );

   assign busy = (st_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         cnt_q     <= '0;
         sgn_q     <= 1'b0;
         lng_q     <= 1'b0;
         hi_q      <= '0;
         lo_q      <= '0;
         d_q       <= '0;
         qn_q      <= 1'b0;
         rn_q      <= 1'b0;
         povf_q    <= 1'b0;
         dz_q      <= 1'b0;
         done      <= 1'b0;
         quot      <= '0;
         rem       <= '0;
         flag_neg  <= 1'b0;
         flag_zero <= 1'b0;
         flag_ovf  <= 1'b0;
         div_zero  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  sgn_q <= is_signed;
                  lng_q <= is_long;
                  hi_q  <= dvd_hi;
                  lo_q  <= dvd_lo;
                  d_q   <= dvsr;
                  st_q  <= ST_PREP;
               end
            end
            ST_PREP: begin
               hi_q   <= p_hi;
               lo_q   <= p_lo;
               d_q    <= p_d;
               qn_q   <= p_qn;
               rn_q   <= p_rn;
               povf_q <= p_ovf;
               dz_q   <= p_dz;
               cnt_q  <= '0;
               st_q   <= ST_ITER;
            end
            ST_ITER: begin
               hi_q  <= s_hi;
               lo_q  <= s_lo;
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CW'(W - 1))
                  st_q <= ST_FIX;
            end
            default: begin
               quot      <= o_q;
               rem       <= o_r;
               flag_neg  <= o_f.neg;
               flag_zero <= o_f.zero;
               flag_ovf  <= o_f.ovf;
               div_zero  <= o_f.dz;
               done      <= 1'b1;
               st_q      <= ST_IDLE;
            end
         endcase
      end
   end

   // cycle counter used only by the latency properties below
   logic [LW-1:0] lat_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lat_q <= '0;
      else if (st_q == ST_IDLE && start)
         lat_q <= LW'(1);
      else if (busy)
         lat_q <= lat_q + 1'b1;
   end

   assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_q == LW'(LAT + 1)) && !busy);
   assert_no_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (lat_q != LW'(1)));
   assert_rem_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !sgn_q && !div_zero && !flag_ovf) |-> (rem < d_q));
   assert_div_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && div_zero) |-> (quot == '0 && rem == '0 && !flag_ovf));
   assert_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(flag_neg && flag_zero));
endmodule

// File: tb/divr_core_tb_top.sv
module divr_core_tb_top;
   localparam int W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, is_signed = 1'b0, is_long = 1'b0;
   logic [W-1:0] dvd_hi = '0, dvd_lo = '0, dvsr = '0;
   logic busy, done, flag_neg, flag_zero, flag_ovf, div_zero;
   logic [W-1:0] quot, rem;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   divr_core #(.W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
      .is_long(is_long), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvsr(dvsr),
      .busy(busy), .done(done), .quot(quot), .rem(rem),
      .flag_neg(flag_neg), .flag_zero(flag_zero), .flag_ovf(flag_ovf),
      .div_zero(div_zero)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model(input bit sg, input bit lg,
                        input logic [W-1:0] h, input logic [W-1:0] l,
                        input logic [W-1:0] d,
                        output logic [W-1:0] eq, output logic [W-1:0] er,
                        output logic [3:0] ef);
      longint dv, dd, q, r, qmax, qmin;
      bit en, ez, ev, edz;
      eq = '0; er = '0; en = 0; ez = 0; ev = 0; edz = 0;
      if (lg) dv = sg ? longint'($signed({h, l})) : longint'({h, l});
      else    dv = sg ? longint'($signed(l)) : longint'(l);
      dd = sg ? longint'($signed(d)) : longint'(d);
      if (dd == 0) edz = 1;
      else begin
         q = dv / dd;
         r = dv % dd;
         if (sg) begin
            qmax = (longint'(1) <<< (W - 1)) - 1;
            qmin = -(longint'(1) <<< (W - 1));
            ev = (q > qmax) || (q < qmin);
         end else
            ev = (q > ((longint'(1) <<< W) - 1));
         if (!ev) begin
            eq = q[W-1:0];
            er = r[W-1:0];
            en = er[W-1];
            ez = (er == '0);
         end
      end
      ef = {en, ez, ev, edz};
   endtask

   task automatic run_op(input bit sg, input bit lg, input logic [W-1:0] h,
                         input logic [W-1:0] l, input logic [W-1:0] d,
                         input bit poke, input string tag);
      logic [W-1:0] eq, er;
      logic [3:0] ef;
      int seen = -1;
      bit busy_ok = 1;
      model(sg, lg, h, l, d, eq, er, ef);
      @(negedge clk);
      is_signed = sg; is_long = lg; dvd_hi = h; dvd_lo = l; dvsr = d;
      start = 1'b1;
      for (int n = 1; n <= 40 && seen < 0; n++) begin
         @(negedge clk);
         if (done) begin
            seen = n;
            chk(quot == eq, tag, "quotient", quot, eq);
            chk(rem == er, tag, "remainder", rem, er);
            chk({flag_neg, flag_zero, flag_ovf, div_zero} == ef, tag,
                "flags{neg,zero,ovf,dz}",
                {flag_neg, flag_zero, flag_ovf, div_zero}, ef);
            if (busy) busy_ok = 0;
         end else if (!busy) busy_ok = 0;
         if (poke && n == 5) begin
            start = 1'b1; dvsr = ~d; dvd_lo = ~l; dvd_hi = ~h;
            is_signed = ~sg;
         end else
            start = 1'b0;
      end
      // R1: done after W+2 cycles, busy across the operation
      chk(seen == W + 3, "R1", "done sample index", seen, W + 3);
      chk(busy_ok, "R1", "busy profile", busy_ok, 1);
      @(negedge clk);
      chk(!done, "R1", "done width", done, 0);
   endtask

   initial begin
      #1_900_000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done, "R1", "reset busy/done", {busy, done}, 0);
      chk(quot == '0 && rem == '0, "R9", "reset results", {quot, rem}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      run_op(0, 0, 16'h0000, 16'd39424, 16'd105, 0, "R3");
      run_op(0, 0, 16'h0000, 16'h9EF0, 16'h018D, 0, "R3");
      run_op(1, 0, 16'h0000, 16'h9A00, 16'd105, 0, "R5");
      run_op(1, 0, 16'h0000, 16'h6600, 16'hFF97, 0, "R5");
      run_op(1, 0, 16'h0000, 16'h9A00, 16'hFF97, 0, "R5");
      run_op(1, 0, 16'h0000, 16'h9EF0, 16'h018D, 0, "R5");
      run_op(0, 1, 16'h0001, 16'h0000, 16'h0001, 0, "R6");
      run_op(0, 1, 16'hFFFE, 16'hFFFF, 16'hFFFF, 0, "R6");
      run_op(0, 1, 16'h0005, 16'h0000, 16'h0005, 0, "R6");
      run_op(1, 0, 16'h0000, 16'h8000, 16'hFFFF, 0, "R7");
      run_op(1, 0, 16'h0000, 16'h8000, 16'h0001, 0, "R7");
      run_op(1, 1, 16'h0000, 16'h8000, 16'h0001, 0, "R7");
      run_op(1, 1, 16'hFFFF, 16'h8000, 16'hFFFF, 0, "R7");
      run_op(0, 0, 16'h0000, 16'h1234, 16'h0000, 0, "R8");
      run_op(1, 1, 16'h8000, 16'h0000, 16'h0000, 0, "R8");
      run_op(0, 0, 16'h1234, 16'h8000, 16'h0002, 0, "R4");
      run_op(1, 0, 16'h1234, 16'h8000, 16'h0002, 0, "R4");
      run_op(0, 0, 16'h0000, 16'd100, 16'd10, 0, "R9");
      run_op(1, 0, 16'h0000, 16'hFF9C, 16'd7, 0, "R9");
      run_op(0, 0, 16'h0000, 16'd39424, 16'd105, 1, "R2");
      run_op(1, 1, 16'hFFFF, 16'h9A00, 16'd105, 1, "R2");

      for (int i = 0; i < 2000; i++) begin
         logic [W-1:0] h, l, d;
         bit sg, lg;
         sg = i[0];
         lg = i[1];
         l  = W'($urandom);
         d  = W'($urandom);
         if (i[3:2] == 2'd0) d = W'($urandom_range(0, 15));
         h  = (i[4]) ? W'($urandom) : (d >> 1);
         run_op(sg, lg, h, l, d, i[5:0] == 6'd7, "R3/R5 sweep");
      end

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule